// File: doc/BRIEF.md
# Virtualization Intercept Decision Decoder

This block holds the intercept configuration of one guest and answers, for one event code per request, whether that event must cause an exit from the guest. Six bitmaps are kept in registers:

- four 16-bit masks for control-register reads, control-register writes, debug-register reads and debug-register writes;
- a 32-bit exception mask;
- a 64-bit general intercept vector.

Each bitmap has its own write strobe. All six share one 64-bit data bus.

A request carries a 12-bit event code. The code space is split into fixed ranges. Each range selects its own bitmap and indexes it by the code's offset from the range base. The answer is registered and comes back one cycle after the request, together with a response strobe.

The answer is only positive while the guest-mode flag is set. An exit pulse wipes the exception mask and the general vector, so a later guest entry must reload them. Fetching bitmaps from memory, the exit sequence itself, and permission-map lookups are done elsewhere.

Top module: `intercept_decider`

## Requirements
- R1: Codes 0x000 to 0x008 test bit (code - 0x000) of the 16-bit control-register read mask. That mask is loaded by strobe bit 0.
- R2: Codes 0x010 to 0x018 test bit (code - 0x010) of the 16-bit control-register write mask. That mask is loaded by strobe bit 1.
- R3: Codes 0x020 to 0x027 test the debug-register read mask, loaded by strobe bit 2. Codes 0x030 to 0x037 test the debug-register write mask, loaded by strobe bit 3. Both masks are 16 bits wide and are indexed by the offset from their base.
- R4: Codes 0x040 to 0x05F test bit (code - 0x040) of the 32-bit exception mask. That mask is loaded by strobe bit 4.
- R5: Codes 0x060 to 0x09F test bit (code - 0x060) of the 64-bit general vector, loaded by strobe bit 5. Any code at or above 0x0A0, and any code in a gap between the ranges above, reports no intercept. There is no wrap-around.
- R6: While guest_i is low at the request, hit_o is low in the response, whatever the bitmaps hold.
- R7: An exit_i pulse clears the exception mask and the general vector by the next cycle. The exit wins over a load of either one in the same cycle. The four register masks keep their contents.
- R8: rsp_valid_o is high exactly in the cycle after each cycle in which req_valid_i is high. hit_o is low whenever rsp_valid_o is low. A request sees the bitmap contents as they were before any write in the same cycle.
- R9: After reset all bitmaps are zero and both outputs are low.
- R10: The narrow bitmaps take the low bits of ld_data_i and ignore the rest. A strobe changes only its own bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 6 | Per-bitmap write strobes (bit index = bitmap number) |
| ld_data_i | input | 64 | Load data, low bits used by narrow bitmaps |
| exit_i | input | 1 | Guest exit pulse, clears exception mask and general vector |
| guest_i | input | 1 | Guest mode flag, sampled with the request |
| req_valid_i | input | 1 | Request strobe |
| code_i | input | 12 | Event code of the request |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| hit_o | output | 1 | Intercept decision for the request |

## Verification
The checker watches the following on every cycle:

- the one-cycle pairing of request and response strobes;
- the absence of a hit outside a response;
- the absence of a hit for requests made in host mode;
- the absence of a hit for codes past the general range;
- the emptiness of the exception and general bitmaps right after an exit.

Which bit each range selects can only be shown by the bench's scenarios:

- range edges and the gaps between ranges;
- strobe isolation;
- a same-cycle load racing a request;
- the survival of the register masks across an exit.

// File: rtl/icpt_pkg.sv
package icpt_pkg;
  localparam int unsigned CODE_W     = 12;
  localparam int unsigned NARROW_W   = 16;
  localparam int unsigned EXC_W      = 32;
  localparam int unsigned GEN_W      = 64;
  localparam int unsigned NUM_NARROW = 4;
  localparam int unsigned NUM_MAPS   = 6;
  localparam int unsigned IDX_W      = $clog2(GEN_W);

  typedef enum logic [2:0] {
    MAP_CRR  = 3'd0,
    MAP_CRW  = 3'd1,
    MAP_DRR  = 3'd2,
    MAP_DRW  = 3'd3,
    MAP_EXC  = 3'd4,
    MAP_GEN  = 3'd5,
    MAP_NONE = 3'd7
  } map_e;

  typedef struct packed {
    map_e             map;
    logic [IDX_W-1:0] idx;
  } route_t;

  // range base per bitmap number
  function automatic int unsigned range_base(int unsigned m);
    case (m)
      0:       return 'h000;
      1:       return 'h010;
      2:       return 'h020;
      3:       return 'h030;
      4:       return 'h040;
      default: return 'h060;
    endcase
  endfunction

  // number of codes per range
  function automatic int unsigned range_span(int unsigned m);
    case (m)
      0, 1:    return 9;
      2, 3:    return 8;
      4:       return EXC_W;
      default: return GEN_W;
    endcase
  endfunction
endpackage

// File: rtl/icpt_route_decode.sv
module icpt_route_decode
  import icpt_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic [CW-1:0] code_i,
  output route_t        route_o
);
  logic [NUM_MAPS-1:0] in_rng;
  logic [IDX_W-1:0]    offs [NUM_MAPS];

  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_rng
    localparam int unsigned BASE  = range_base(m);
    localparam int unsigned LIMIT = BASE + range_span(m);
    logic lo_ok;
    logic hi_ok;
    if (BASE == 0) begin : g_zero
      assign lo_ok = 1'b1;
    end else begin : g_nz
      assign lo_ok = (code_i >= CW'(BASE));
    end
    assign hi_ok     = (code_i < CW'(LIMIT));
    assign in_rng[m] = lo_ok & hi_ok;
    assign offs[m]   = IDX_W'(code_i - CW'(BASE));
  end

  // ranges are disjoint; lowest number wins for safety
  always_comb begin
    route_o.map = MAP_NONE;
    route_o.idx = '0;
    for (int m = NUM_MAPS - 1; m >= 0; m--) begin
      if (in_rng[m]) begin
        route_o.map = map_e'(3'(m));
        route_o.idx = offs[m];
      end
    end
  end
endmodule

// File: rtl/icpt_bitmap_bank.sv
module icpt_bitmap_bank
  import icpt_pkg::*;
(
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_MAPS-1:0]                  ld_en_i,
  input  logic [GEN_W-1:0]                     ld_data_i,
  input  logic                                 exit_i,
  output logic [NUM_NARROW-1:0][NARROW_W-1:0]  narrow_o,
  output logic [EXC_W-1:0]                     exc_o,
  output logic [GEN_W-1:0]                     gen_o
);
  logic [NUM_NARROW-1:0][NARROW_W-1:0] narrow_q;
  logic [EXC_W-1:0]                    exc_q;
  logic [GEN_W-1:0]                    gen_q;

  for (genvar k = 0; k < NUM_NARROW; k++) begin : g_narrow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         narrow_q[k] <= '0;
      else if (ld_en_i[k]) narrow_q[k] <= ld_data_i[NARROW_W-1:0];
    end
  end

  // exit has priority over a same-cycle load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                exc_q <= '0;
    else if (exit_i)            exc_q <= '0;
    else if (ld_en_i[MAP_EXC])  exc_q <= ld_data_i[EXC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gen_q <= '0;
    else if (exit_i)            gen_q <= '0;
    else if (ld_en_i[MAP_GEN])  gen_q <= ld_data_i;
  end

  assign narrow_o = narrow_q;
  assign exc_o    = exc_q;
  assign gen_o    = gen_q;
endmodule

// File: rtl/icpt_bit_select.sv
module icpt_bit_select
  import icpt_pkg::*;
(
  input  route_t                               route_i,
  input  logic [NUM_NARROW-1:0][NARROW_W-1:0]  narrow_i,
  input  logic [EXC_W-1:0]                     exc_i,
  input  logic [GEN_W-1:0]                     gen_i,
  output logic                                 bit_o
);
  localparam int unsigned NW_IDX = $clog2(NARROW_W);
  localparam int unsigned EX_IDX = $clog2(EXC_W);

  always_comb begin
    unique case (route_i.map)
      MAP_CRR, MAP_CRW, MAP_DRR, MAP_DRW:
        bit_o = narrow_i[route_i.map[1:0]][route_i.idx[NW_IDX-1:0]];
      MAP_EXC: bit_o = exc_i[route_i.idx[EX_IDX-1:0]];
      MAP_GEN: bit_o = gen_i[route_i.idx];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/intercept_decider.sv
module intercept_decider
  import icpt_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_MAPS-1:0] ld_en_i,
  input  logic [GEN_W-1:0]    ld_data_i,
  input  logic                exit_i,
  input  logic                guest_i,
  input  logic                req_valid_i,
  input  logic [CW-1:0]       code_i,
  output logic                rsp_valid_o,
  output logic                hit_o
);
  logic [NUM_NARROW-1:0][NARROW_W-1:0] narrow_map;
  logic [EXC_W-1:0]                    exc_map;
  logic [GEN_W-1:0]                    gen_map;
  route_t                              route;
  logic                                sel_bit;
  logic                                rsp_q;
  logic                                hit_q;

  icpt_route_decode #(.CW(CW)) i_decode (
    .code_i  (code_i),
    .route_o (route)
  );

  icpt_bitmap_bank i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_en_i),
    .ld_data_i (ld_data_i),
    .exit_i    (exit_i),
    .narrow_o  (narrow_map),
    .exc_o     (exc_map),
    .gen_o     (gen_map)
  );

  icpt_bit_select i_select (
    .route_i  (route),
    .narrow_i (narrow_map),
    .exc_i    (exc_map),
    .gen_i    (gen_map),
    .bit_o    (sel_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      rsp_q <= req_valid_i;
      hit_q <= req_valid_i & guest_i & sel_bit;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign hit_o       = hit_q;
endmodule

// File: rtl/icpt_checker.sv
module icpt_checker
  import icpt_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             guest_i,
  input logic [CW-1:0]    code_i,
  input logic             exit_i,
  input logic             rsp_valid_o,
  input logic             hit_o,
  input logic [EXC_W-1:0] exc_map,
  input logic [GEN_W-1:0] gen_map
);
  localparam int unsigned PAST_GEN = range_base(MAP_GEN) + GEN_W;

  assert_rsp_follows_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_hit_only_in_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rsp_valid_o);

  assert_host_never_hits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !guest_i) |=> !hit_o);

  assert_no_wrap_past_gen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && code_i >= CW'(PAST_GEN)) |=> !hit_o);

  assert_exit_wipes_maps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_i |=> (exc_map == '0 && gen_map == '0));
endmodule

bind intercept_decider icpt_checker #(.CW(CW)) i_icpt_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .guest_i     (guest_i),
  .code_i      (code_i),
  .exit_i      (exit_i),
  .rsp_valid_o (rsp_valid_o),
  .hit_o       (hit_o),
  .exc_map     (exc_map),
  .gen_map     (gen_map)
);

// File: tb/test_intercept_decider.sv
module test_intercept_decider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  ld_en_i = '0;
  logic [63:0] ld_data_i = '0;
  logic        exit_i = 1'b0;
  logic        guest_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [11:0] code_i = '0;
  logic        rsp_valid_o;
  logic        hit_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  intercept_decider i_intercept_decider (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_en_i     (ld_en_i),
    .ld_data_i   (ld_data_i),
    .exit_i      (exit_i),
    .guest_i     (guest_i),
    .req_valid_i (req_valid_i),
    .code_i      (code_i),
    .rsp_valid_o (rsp_valid_o),
    .hit_o       (hit_o)
  );

  typedef struct packed {
    logic [11:0] code;
    logic        guest;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 1'b1, 1'b1, 4'd1},  // R1 low edge
    '{12'h001, 1'b1, 1'b0, 4'd1},  // R1
    '{12'h008, 1'b1, 1'b1, 4'd1},  // R1 high edge
    '{12'h009, 1'b1, 1'b0, 4'd5},  // R5 gap, mask bit 9 set but unused
    '{12'h010, 1'b1, 1'b0, 4'd2},  // R2 own mask, not CR read
    '{12'h018, 1'b1, 1'b1, 4'd2},  // R2
    '{12'h019, 1'b1, 1'b0, 4'd5},  // R5 gap
    '{12'h020, 1'b1, 1'b0, 4'd3},  // R3
    '{12'h027, 1'b1, 1'b1, 4'd3},  // R3 read edge
    '{12'h028, 1'b1, 1'b0, 4'd5},  // R5 gap, bit 8 set but unused
    '{12'h030, 1'b1, 1'b1, 4'd3},  // R3 write
    '{12'h031, 1'b1, 1'b0, 4'd3},  // R3
    '{12'h040, 1'b1, 1'b1, 4'd4},  // R4
    '{12'h041, 1'b1, 1'b0, 4'd4},  // R4
    '{12'h05F, 1'b1, 1'b1, 4'd4},  // R4 top
    '{12'h060, 1'b1, 1'b1, 4'd5},  // R5
    '{12'h061, 1'b1, 1'b0, 4'd5},  // R5 and R10 garbage load kept out
    '{12'h09F, 1'b1, 1'b1, 4'd5},  // R5 top
    '{12'h0A0, 1'b1, 1'b0, 4'd5},  // R5 offset 64
    '{12'h0E0, 1'b1, 1'b0, 4'd5},  // R5 offset 128, no wrap
    '{12'h040, 1'b0, 1'b0, 4'd6},  // R6
    '{12'h000, 1'b0, 1'b0, 4'd6},  // R6
    '{12'h09F, 1'b0, 1'b0, 4'd6}   // R6
  };

  task automatic check(input logic act, input logic exp, input int r, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b", r, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [11:0] c, input logic g, input logic e, input int r);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    code_i      = c;
    guest_i     = g;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    checks++;
    if (rsp_valid_o !== 1'b1 || hit_o !== e) begin
      fails++;
      $display("FAIL R%0d code %h: actual rsp=%b hit=%b expected rsp=1 hit=%b",
               r, c, rsp_valid_o, hit_o, e);
    end
  endtask

  task automatic load(input int idx, input logic [63:0] d);
    @(negedge clk_i);
    ld_en_i      = '0;
    ld_en_i[idx] = 1'b1;
    ld_data_i    = d;
    @(negedge clk_i);
    ld_en_i = '0;
  endtask

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(rsp_valid_o, 1'b0, 9, "rsp after reset");
    check(hit_o, 1'b0, 9, "hit after reset");
    rst_ni = 1'b1;
    do_req(12'h000, 1'b1, 1'b0, 9);   // R9 maps empty
    do_req(12'h060, 1'b1, 1'b0, 9);
    @(negedge clk_i);
    check(rsp_valid_o, 1'b0, 8, "rsp drops when idle");   // R8

    // R10 high garbage on narrow loads
    load(0, 64'hFFFF_FFFF_FFFF_0305);
    load(1, 64'h0000_0000_0000_0100);
    load(2, 64'h0000_0000_0000_0180);
    load(3, 64'h0000_0000_0000_0001);
    load(4, 64'h0000_0000_8000_0001);
    load(5, 64'h8000_0000_0000_0001);

    for (int i = 0; i < NV; i++)
      do_req(VECS[i].code, VECS[i].guest, VECS[i].exp, int'(VECS[i].req));

    // R8 same-cycle load is not seen by the request
    @(negedge clk_i);
    req_valid_i = 1'b1; code_i = 12'h061; guest_i = 1'b1;
    ld_en_i = 6'b100000; ld_data_i = 64'h8000_0000_0000_0003;
    @(negedge clk_i);
    req_valid_i = 1'b0; ld_en_i = '0;
    check(hit_o, 1'b0, 8, "old map used in load cycle");
    do_req(12'h061, 1'b1, 1'b1, 8);

    // R7 exit beats a same-cycle exception load
    @(negedge clk_i);
    exit_i = 1'b1; ld_en_i = 6'b010000; ld_data_i = '1;
    @(negedge clk_i);
    exit_i = 1'b0; ld_en_i = '0;
    do_req(12'h040, 1'b1, 1'b0, 7);
    do_req(12'h05F, 1'b1, 1'b0, 7);
    do_req(12'h060, 1'b1, 1'b0, 7);
    do_req(12'h09F, 1'b1, 1'b0, 7);
    do_req(12'h000, 1'b1, 1'b1, 7);   // register masks survive
    do_req(12'h030, 1'b1, 1'b1, 7);

    // R4 reload after exit, R10 isolation
    load(4, 64'h0000_0000_0000_0008);
    do_req(12'h043, 1'b1, 1'b1, 4);
    do_req(12'h060, 1'b1, 1'b0, 10);
    do_req(12'h018, 1'b1, 1'b1, 10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule